// File: doc/BRIEF.md
# Recirculating Longest-Prefix Route Lookup

This block resolves 32-bit IPv4 destination addresses to route results by walking a three-level trie held in one external pipelined memory. The top 16 address bits index the first level directly. Each entry read is either a final result or a pointer to a 256-entry block of the next level, which is indexed by the next 8 address bits. A lookup therefore costs one, two or three dependent reads.

Every lookup uses the same memory request port. A lookup whose read returns a pointer goes straight back to the port for its next read, so new and continuing lookups interleave on that one port. Each address takes a reorder slot when it is accepted. A finished lookup writes its result into that slot, and results leave on a valid/ready output strictly in acceptance order, even when a short lookup finishes before a long one that entered earlier.

Table entries use bit 31 as the result flag. When it is 1, bits 30:0 are the result value. When it is 0, the low `MEM_AW` bits are the base address of the next-level block. The memory takes one request per cycle and returns each read exactly `MEM_LAT` cycles later.

Top module: `lpm_ring`

## Requirements
- R1: When an address is accepted (`in_valid` and `in_ready` both high), the block issues a memory request in the same cycle at address `in_addr[31:16]`, zero-extended to `MEM_AW` bits.
- R2: A response with bit 31 set ends its lookup, and bits 30:0 of that response become the lookup's result.
- R3: A response with bit 31 clear at the first level causes a request in the same cycle at `response[MEM_AW-1:0] + in_addr[15:8]`. At the second level the request address is `response[MEM_AW-1:0] + in_addr[7:0]`.
- R4: The response of the third read always ends the lookup, so no lookup makes more than three reads.
- R5: Exactly one result is delivered for each accepted address, and results leave in the order the addresses were accepted.
- R6: A continuing lookup has priority for the memory port. In any cycle in which a response needs a further read, `in_ready` is low and the further read is issued.
- R7: At most `TOKENS` lookups are held between acceptance and delivery. While `TOKENS` are held, `in_ready` is low.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` stays unchanged in the next cycle.
- R9: With the block otherwise idle and `out_ready` high, a lookup of k reads presents its result k*`MEM_LAT`+1 cycles after the cycle in which it was accepted.
- R10: After a synchronous reset, `out_valid` and `mem_req_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Address accepted this cycle if offered |
| in_addr | input | 32 | IPv4 address to resolve |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 31 | Route result of the oldest unfinished address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | MEM_AW | Memory read address |
| mem_rsp_valid | input | 1 | Read data returned, MEM_LAT cycles after its request |
| mem_rsp_data | input | 32 | Table entry read |

## Verification
A lookup's first request is due in its acceptance cycle, and each later request is due in the cycle of the previous response. That response comes exactly `MEM_LAT` cycles after the request. The result follows one cycle after the final response, so with the block idle it appears k*`MEM_LAT`+1 cycles after acceptance. The bench counts cycles from the negative edge at which it sees the handshake and checks that distance for one-, two- and three-read lookups. All inputs change just after a rising edge and all outputs are compared at the falling edge, so each comparison sees the values that the next rising edge will act on. A queue of expected results, computed by walking the bench's own table, is compared with every delivered result. The port rules for the first request, priority, reorder-slot limit and output hold are checked in every cycle in which they apply.

// File: rtl/lpm_pkg.sv
// Shared constants and types for the recirculating prefix lookup.
// Assumes 32-bit addresses split 16/8/8 over three trie levels.
package lpm_pkg;
    localparam int IP_W     = 32;
    localparam int L1_W     = 16;
    localparam int STEP_W   = 8;
    localparam int REM_W    = IP_W - L1_W;
    localparam int ENTRY_W  = 32;
    localparam int LEAF_BIT = ENTRY_W - 1;
    localparam int RES_W    = ENTRY_W - 1;

    typedef enum logic [1:0] {
        LVL_ONE   = 2'd0,
        LVL_TWO   = 2'd1,
        LVL_THREE = 2'd2
    } lvl_e;
endpackage

// File: rtl/lpm_fifo.sv
// In-order queue of lookups whose memory reads are outstanding.
// Assumes the caller never pushes when full; push and pop may coincide.
module lpm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;

    assign head = store[rptr];
    assign full = (cnt == CW'(DEPTH));

    // Pointer and count bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // Entry storage, written at the tail.
    always_ff @(posedge clk) begin
        if (push) store[wptr] <= push_data;
    end
endmodule

// File: rtl/lpm_cbuf.sv
// Reorder buffer: hands out slots in arrival order, accepts results
// in any order, releases them in slot order.
// Assumes a slot is completed at most once between allocation and release.
module lpm_cbuf #(
    parameter int TOKENS = 8,
    parameter int DW     = 31,
    parameter int TOK_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    output logic             alloc_ok_o,
    output logic [TOK_W-1:0] alloc_tok_o,
    input  logic             done_i,
    input  logic [TOK_W-1:0] done_tok_i,
    input  logic [DW-1:0]    done_data_i,
    output logic             out_valid_o,
    output logic [DW-1:0]    out_data_o,
    input  logic             out_ready_i
);
    localparam int CW = $clog2(TOKENS + 1);

    logic [TOKENS-1:0] vld;
    logic [DW-1:0]     dat [TOKENS];
    logic [TOK_W-1:0]  wr, rd;
    logic [CW-1:0]     cnt;
    logic              take, deliver;

    assign alloc_ok_o  = (cnt < CW'(TOKENS));
    assign alloc_tok_o = wr;
    assign out_valid_o = vld[rd];
    assign out_data_o  = dat[rd];
    assign take        = alloc_i && alloc_ok_o;
    assign deliver     = out_valid_o && out_ready_i;

    // Allocation, release and occupancy counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr  <= '0;
            rd  <= '0;
            cnt <= '0;
        end else begin
            if (take)    wr <= (wr == TOK_W'(TOKENS - 1)) ? '0 : wr + 1'b1;
            if (deliver) rd <= (rd == TOK_W'(TOKENS - 1)) ? '0 : rd + 1'b1;
            cnt <= cnt + CW'(take) - CW'(deliver);
        end
    end

    // Per-slot finished flags: set on completion, cleared on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (deliver) vld[rd] <= 1'b0;
            if (done_i)  vld[done_tok_i] <= 1'b1;
        end
    end

    // Result storage per slot.
    always_ff @(posedge clk) begin
        if (done_i) dat[done_tok_i] <= done_data_i;
    end
endmodule

// File: rtl/lpm_ring.sv
// Longest-prefix lookup over a three-level trie in one pipelined memory.
// New lookups and continuing lookups share the single request port, with
// continuing lookups first. Assumes the memory returns every read exactly
// MEM_LAT cycles after its request, in request order.
module lpm_ring #(
    parameter int MEM_AW  = 18,
    parameter int MEM_LAT = 4,
    parameter int TOKENS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [30:0]       out_result,
    output logic              mem_req_valid,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);
    import lpm_pkg::*;

    localparam int TOK_W  = (TOKENS > 1) ? $clog2(TOKENS) : 1;
    localparam int QDEPTH = MEM_LAT + 1;

    typedef struct packed {
        logic [REM_W-1:0] rem;
        lvl_e             lvl;
        logic [TOK_W-1:0] tok;
    } flight_t;
    localparam int FW = $bits(flight_t);

    logic [FW-1:0]     q_head;
    flight_t           head_q, push_q;
    logic              q_full;
    logic              tok_ok;
    logic [TOK_W-1:0]  new_tok;
    logic              rsp_leaf, finish, recirc, enter;
    logic [STEP_W-1:0] step_bits;
    logic [MEM_AW-1:0] next_addr;

    assign head_q = flight_t'(q_head);

    // Classify the returning read: final result or another level to walk.
    always_comb begin
        rsp_leaf  = mem_rsp_data[LEAF_BIT];
        finish    = mem_rsp_valid && (rsp_leaf || head_q.lvl == LVL_THREE);
        recirc    = mem_rsp_valid && !finish;
        step_bits = head_q.rem[REM_W-1 -: STEP_W];
        next_addr = mem_rsp_data[MEM_AW-1:0] + MEM_AW'(step_bits);
    end

    // Port arbitration: a continuing lookup blocks new entry.
    assign in_ready      = !recirc && tok_ok && !q_full;
    assign enter         = in_valid && in_ready;
    assign mem_req_valid = recirc || enter;
    assign mem_req_addr  = recirc ? next_addr : MEM_AW'(in_addr[IP_W-1 -: L1_W]);

    // Tag that travels with the request into the in-flight queue.
    always_comb begin
        if (recirc) begin
            push_q.rem = head_q.rem << STEP_W;
            push_q.lvl = (head_q.lvl == LVL_ONE) ? LVL_TWO : LVL_THREE;
            push_q.tok = head_q.tok;
        end else begin
            push_q.rem = in_addr[REM_W-1:0];
            push_q.lvl = LVL_ONE;
            push_q.tok = new_tok;
        end
    end

    lpm_fifo #(.W(FW), .DEPTH(QDEPTH)) u_flight (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (mem_req_valid),
        .push_data (push_q),
        .pop       (mem_rsp_valid),
        .head      (q_head),
        .full      (q_full)
    );

    lpm_cbuf #(.TOKENS(TOKENS), .DW(RES_W), .TOK_W(TOK_W)) u_order (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (enter),
        .alloc_ok_o  (tok_ok),
        .alloc_tok_o (new_tok),
        .done_i      (finish),
        .done_tok_i  (head_q.tok),
        .done_data_i (mem_rsp_data[RES_W-1:0]),
        .out_valid_o (out_valid),
        .out_data_o  (out_result),
        .out_ready_i (out_ready)
    );
endmodule

// File: rtl/lpm_ring_chk.sv
// Property checker for lpm_ring, attached by bind below.
// Assumes the memory is well behaved (fixed latency, in order).
module lpm_ring_chk #(
    parameter int MEM_AW = 18,
    parameter int TOKENS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [31:0]       in_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [30:0]       out_result,
    input logic              mem_req_valid,
    input logic [MEM_AW-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic [31:0]       mem_rsp_data,
    input logic [1:0]        head_lvl,
    input logic [15:0]       head_rem
);
    localparam int OW = $clog2(TOKENS + 1) + 1;
    logic [OW-1:0] occ;

    // Lookups held between acceptance and delivery, counted at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ + OW'(in_valid && in_ready) - OW'(out_valid && out_ready);
    end

    a_r1_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (mem_req_valid && mem_req_addr == MEM_AW'(in_addr[31:16])));

    a_r3_level_two_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && !mem_rsp_data[31] && head_lvl == 2'd0) |->
        (mem_req_valid && mem_req_addr == MEM_AW'(mem_rsp_data[MEM_AW-1:0] + MEM_AW'(head_rem[15:8]))));

    a_r4_third_is_final: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && head_lvl == 2'd2) |-> (!mem_req_valid || (in_valid && in_ready)));

    a_r6_recirc_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && !mem_rsp_data[31] && head_lvl != 2'd2) |-> (!in_ready && mem_req_valid));

    a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(TOKENS));

    a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OW'(TOKENS)) |-> !in_ready);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));
endmodule

bind lpm_ring lpm_ring_chk #(.MEM_AW(MEM_AW), .TOKENS(TOKENS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_addr       (in_addr),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_result    (out_result),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .head_lvl      (head_q.lvl),
    .head_rem      (head_q.rem)
);

// File: tb/test_lpm_ring.sv
// Bench for lpm_ring: fixed-latency table memory, behavioural reference
// queue, per-cycle port checks.
module test_lpm_ring;
    localparam int AW   = 18;
    localparam int LAT  = 4;
    localparam int NTOK = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   in_addr = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [30:0]   out_result;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid;
    logic [31:0]   mem_rsp_data;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int accepted = 0;
    int delivered = 0;
    bit rand_ready = 1'b0;
    bit finished = 1'b0;
    bit prev_hold = 1'b0;
    logic [30:0] prev_res;
    logic [30:0] exp_q [$];

    always #4 clk = ~clk;   // 125 MHz

    lpm_ring #(.MEM_AW(AW), .MEM_LAT(LAT), .TOKENS(NTOK)) i_lpm_ring (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Table content as a pure function of the memory address.
    function automatic logic [31:0] tbl(input logic [AW-1:0] a);
        int unsigned u = 32'(a);
        if (u < 32'h10000) begin
            if (u % 3 == 0) return {1'b0, 31'(32'h10000 + (u % 64) * 256)};
            return {1'b1, 31'(u * 7 + 1)};
        end else if (u < 32'h20000) begin
            if (u % 4 == 1) return {1'b0, 31'(32'h20000 + ((u >> 8) % 64) * 256)};
            return {1'b1, 31'(u * 11 + 3)};
        end
        return {1'b1, 31'(u * 13 + 5)};
    endfunction

    // Reference walk of the trie.
    function automatic logic [30:0] ref_lpm(input logic [31:0] ip);
        logic [31:0] p;
        p = tbl(AW'(ip[31:16]));
        if (p[31]) return p[30:0];
        p = tbl(AW'(p[AW-1:0] + AW'(ip[15:8])));
        if (p[31]) return p[30:0];
        p = tbl(AW'(p[AW-1:0] + AW'(ip[7:0])));
        return p[30:0];
    endfunction

    // Fixed-latency pipelined memory model.
    logic [LAT-1:0] pv;
    logic [31:0]    pd [LAT];
    assign mem_rsp_valid = pv[LAT-1];
    assign mem_rsp_data  = pd[LAT-1];
    always @(posedge clk) begin
        if (!rst_n) pv <= '0;
        else        pv <= {pv[LAT-2:0], mem_req_valid};
        pd[0] <= tbl(mem_req_addr);
        for (int i = 1; i < LAT; i++) pd[i] <= pd[i-1];
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Per-cycle reference comparison at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold)
                chk(out_valid && out_result == prev_res, "R8 hold",
                    {out_valid, out_result}, {1'b1, prev_res});
            if (accepted - delivered == NTOK)
                chk(!in_ready, "R7 token limit", 32'(in_ready), 32'd0);
            if (mem_rsp_valid && !mem_rsp_data[31])
                chk(!in_ready && mem_req_valid, "R6 recirculation priority",
                    {in_ready, mem_req_valid}, 32'b01);
            if (in_valid && in_ready) begin
                chk(mem_req_valid && mem_req_addr == AW'(in_addr[31:16]), "R1 first read",
                    32'(mem_req_addr), 32'(in_addr[31:16]));
                exp_q.push_back(ref_lpm(in_addr));
                accepted++;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected result", 32'(out_result), 32'd0);
                end else begin
                    logic [30:0] e;
                    e = exp_q.pop_front();
                    chk(out_result == e, "R2 R3 R4 R5 result", 32'(out_result), 32'(e));
                end
                delivered++;
            end
            prev_hold = out_valid && !out_ready;
            prev_res  = out_result;
        end
    end

    // Random consumer back-pressure.
    initial forever begin
        @(posedge clk); #1;
        if (rand_ready) out_ready = ($urandom_range(0, 3) != 0);
    end

    // Offer one address and return just after the edge that takes it.
    task automatic send(input logic [31:0] a);
        in_valid = 1'b1;
        in_addr  = a;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic lat_test(input logic [31:0] a, input int k);
        int t0;
        in_valid = 1'b1;
        in_addr  = a;
        @(negedge clk);
        t0 = cyc;
        chk(in_ready, "R9 idle accept", 32'(in_ready), 32'd1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        while (!out_valid && cyc - t0 < 100) @(negedge clk);
        chk(cyc - t0 == k * LAT + 1, "R9 latency", 32'(cyc - t0), 32'(k * LAT + 1));
        @(posedge clk); #1;
    endtask

    task automatic drain();
        int n = 0;
        in_valid = 1'b0;
        while ((exp_q.size() != 0 || out_valid) && n < 2000) begin
            @(posedge clk); #1;
            n++;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!out_valid, "R10 out_valid after reset", 32'(out_valid), 32'd0);
        chk(!mem_req_valid, "R10 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
        chk(in_ready, "R10 in_ready after reset", 32'(in_ready), 32'd1);
        @(posedge clk); #1;

        // R9 isolated lookups of one, two and three reads
        out_ready = 1'b1;
        lat_test(32'h0001_1234, 1);
        drain();
        lat_test(32'h0003_0077, 2);
        drain();
        lat_test(32'h0003_01AB, 3);
        drain();

        // Back-to-back stream, random addresses and back-pressure
        rand_ready = 1'b1;
        for (int n = 0; n < 400; n++) begin
            send($urandom);
            if ($urandom_range(0, 7) == 0) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
        end
        // Stream of addresses whose first level always needs more reads
        for (int n = 0; n < 100; n++) send({16'(3 * $urandom_range(0, 20000)), 16'($urandom)});
        rand_ready = 1'b0;
        out_ready  = 1'b1;
        drain();

        // R7: consumer stalled, every slot taken, next address held off
        out_ready = 1'b0;
        for (int n = 0; n < NTOK; n++) send(32'h0005_0000 + 32'(n));
        in_valid = 1'b1;
        in_addr  = 32'h0007_0000;
        repeat (30) @(negedge clk);
        chk(!in_ready, "R7 blocked while full", 32'(in_ready), 32'd0);
        @(posedge clk); #1;
        out_ready = 1'b1;
        send(32'h0007_0000);
        drain();

        // R5: one result per accepted address
        chk(delivered == accepted && exp_q.size() == 0, "R5 count",
            32'(delivered), 32'(accepted));

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R5 watchdog: delivered %0d expected %0d", delivered, accepted);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule